// File: doc/BRIEF.md
# Operand Collector Source-Slot Allocator

This block fills the source-operand slot table of one operand collector unit at the moment the collector takes a new instruction from the issue pipeline register. The table holds twice as many slots as an instruction has source fields. The lower half mirrors the primary instruction field by field. The upper half receives, densely packed, the source registers of co-issued sets that belong to other warps. Every filled slot carries its register number, the warp that owns it and the register bank it will be read from, and it raises a not-ready bit that the read arbitration stage uses later.

The collector accepts an instruction only while it is idle. Acceptance is signalled by a one-cycle pulse that the pipeline register uses to dequeue. The collector then stays busy until the downstream stage signals completion. Within each instruction, a register that repeats an earlier field of the same instruction is read once only. Duplicate removal starts again for every co-issued set.

Top module: `opc_slot_alloc`

## Requirements
- R1: `accept_o` is high in exactly the cycle in which `in_valid` is high and `busy_o` is low. At that clock edge the slot table, `not_ready_o`, `own_warp_o` (the primary warp) and `own_has_sets_o` are loaded, and `busy_o` rises. All of these are visible in the following cycle.
- R2: While `busy_o` is high, `in_valid` is ignored: no accept pulse is given and the table is unchanged. A high `done_i` clears `busy_o` at the next edge.
- R3: Primary source field k (bits [k*8 +: 8] of `in_src_reg`, valid when `in_src_vld[k]` is 1) goes to slot k. An invalid field leaves slot k empty, and no primary register is moved to another slot.
- R4: A primary field whose register equals that of an earlier valid primary field leaves its own slot empty.
- R5: Registers of co-issued sets are packed from slot 4 (the per-instruction field count) upward, in order of set index and then field index. Only registers that are kept take a slot.
- R6: A co-issued set is skipped completely when any of the following holds: `in_has_sets` is 0, its `set_vld` bit is 0, its `set_has_inst` bit is 0, or its warp (`set_warp[s*5 +: 5]`) equals `in_warp`.
- R7: Duplicate removal restarts for each set. A register is dropped only if it repeats an earlier valid field of the same set. Matches with the primary instruction or with other sets do not drop it.
- R8: Packing stops at the last slot (slot 7). Further co-issued registers are discarded.
- R9: Every slot that is not filled reads back as register 0, warp 0, bank 0, with its not-ready bit at 0.
- R10: A primary slot carries `in_warp` and a co-issued slot carries its set's warp. With the default sub-core mode the bank is sched*4 + ((reg + warp) mod 4), using the primary scheduler ID for every slot. With sub-core mode off the bank is (reg + warp) mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pipeline register holds a non-empty ready instruction |
| in_warp | input | 5 | Primary warp ID |
| in_sched | input | 2 | Scheduler ID of the instruction |
| in_has_sets | input | 1 | Instruction carries co-issued sets |
| in_src_vld | input | 4 | Valid bit per primary source field |
| in_src_reg | input | 32 | Primary source registers, field k at [k*8 +: 8] |
| set_vld | input | 3 | Valid bit per co-issued set descriptor |
| set_warp | input | 15 | Warp per set, set s at [s*5 +: 5] |
| set_has_inst | input | 3 | Set has a source instruction |
| set_src_vld | input | 12 | Field valid bits, set s field k at bit s*4+k |
| set_src_reg | input | 96 | Set registers, set s field k at [(s*4+k)*8 +: 8] |
| done_i | input | 1 | Collector finished; clears busy |
| accept_o | output | 1 | One-cycle dequeue pulse |
| busy_o | output | 1 | Collector holds an instruction |
| own_warp_o | output | 5 | Latched primary warp ID |
| own_has_sets_o | output | 1 | Latched co-issued-set flag |
| not_ready_o | output | 8 | Not-ready bit per slot |
| slot_reg_o | output | 64 | Register per slot, slot i at [i*8 +: 8] |
| slot_warp_o | output | 40 | Owning warp per slot, slot i at [i*5 +: 5] |
| slot_bank_o | output | 32 | Bank per slot, slot i at [i*4 +: 4] |

## Verification
The fill logic is tried with these patterns:
- A fully valid primary instruction with no sets, which shows the fixed lower-half mapping.
- A primary instruction with a repeated register and a hole, which separates dropping a field from shifting the later fields.
- All-invalid fields after a full table, which shows whether stale slots are cleared.
- Sets with a same-warp descriptor, a descriptor that is not valid, and one with no source instruction. These separate the skip conditions from dense packing, and registers shared between sets or with the primary show that duplicate removal is per instruction.
- An oversubscribed case that tells clipping at the last slot from wrap-around.
- A valid set while the co-issue flag is low.

A directed sequence drives a new instruction while the collector is busy, and again in the same cycle as completion, to separate refusal from acceptance.

// File: rtl/opc_slot_pkg.sv
package opc_slot_pkg;

    localparam int NUM_SRC         = 4;
    localparam int NUM_SETS        = 3;
    localparam int NSLOT           = 2 * NUM_SRC;
    localparam int REG_W           = 8;
    localparam int WARP_W          = 5;
    localparam int SCHED_W         = 2;
    localparam int BANKS_PER_SCHED = 4;
    localparam int NUM_BANKS       = (1 << SCHED_W) * BANKS_PER_SCHED;
    localparam int BANK_W          = $clog2(NUM_BANKS);

    typedef struct packed {
        logic [REG_W-1:0]  rnum;
        logic [WARP_W-1:0] warp;
        logic [BANK_W-1:0] bank;
    } slot_t;

    // Bank selection: register offset by warp, optionally confined to the
    // scheduler's own group of banks.
    function automatic logic [BANK_W-1:0] bank_of(
        input logic [REG_W-1:0]   r,
        input logic [WARP_W-1:0]  w,
        input logic [SCHED_W-1:0] s,
        input logic               sub_core
    );
        int t;
        t = int'(r) + int'(w);
        if (sub_core)
            t = int'(s) * BANKS_PER_SCHED + (t % BANKS_PER_SCHED);
        else
            t = t % NUM_BANKS;
        return BANK_W'(t);
    endfunction

endpackage

// File: rtl/opc_src_dedup.sv
module opc_src_dedup
    import opc_slot_pkg::*;
(
    input  logic [NUM_SRC-1:0]       vld_i,
    input  logic [NUM_SRC*REG_W-1:0] regs_i,
    output logic [NUM_SRC-1:0]       keep_o
);

    // A field is kept when valid and not equal to any earlier valid field.
    always_comb begin
        for (int k = 0; k < NUM_SRC; k++) begin
            keep_o[k] = vld_i[k];
            for (int j = 0; j < NUM_SRC; j++) begin
                if (j < k && vld_i[j] &&
                    regs_i[j*REG_W +: REG_W] == regs_i[k*REG_W +: REG_W])
                    keep_o[k] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/opc_slot_pack.sv
module opc_slot_pack
    import opc_slot_pkg::*;
#(
    parameter logic SUB_CORE = 1'b1
) (
    input  logic [NUM_SRC-1:0]                prim_keep_i,
    input  logic [NUM_SRC*REG_W-1:0]          prim_regs_i,
    input  logic [WARP_W-1:0]                 prim_warp_i,
    input  logic [SCHED_W-1:0]                sched_i,
    input  logic [NUM_SETS-1:0]               set_en_i,
    input  logic [NUM_SETS*NUM_SRC-1:0]       set_keep_i,
    input  logic [NUM_SETS*NUM_SRC*REG_W-1:0] set_regs_i,
    input  logic [NUM_SETS*WARP_W-1:0]        set_warps_i,
    output slot_t [NSLOT-1:0]                 slots_o,
    output logic [NSLOT-1:0]                  fill_o
);

    always_comb begin
        int idx;
        logic [REG_W-1:0]  r;
        logic [WARP_W-1:0] w;
        slots_o = '0;
        fill_o  = '0;
        // Fixed positions for the primary instruction.
        for (int k = 0; k < NUM_SRC; k++) begin
            r = prim_regs_i[k*REG_W +: REG_W];
            if (prim_keep_i[k]) begin
                slots_o[k].rnum = r;
                slots_o[k].warp = prim_warp_i;
                slots_o[k].bank = bank_of(r, prim_warp_i, sched_i, SUB_CORE);
                fill_o[k]       = 1'b1;
            end
        end
        // Dense packing for co-issued sets, clipped at the table end.
        idx = NUM_SRC;
        for (int s = 0; s < NUM_SETS; s++) begin
            w = set_warps_i[s*WARP_W +: WARP_W];
            for (int k = 0; k < NUM_SRC; k++) begin
                r = set_regs_i[(s*NUM_SRC+k)*REG_W +: REG_W];
                if (set_en_i[s] && set_keep_i[s*NUM_SRC+k] && idx < NSLOT) begin
                    slots_o[idx].rnum = r;
                    slots_o[idx].warp = w;
                    slots_o[idx].bank = bank_of(r, w, sched_i, SUB_CORE);
                    fill_o[idx]       = 1'b1;
                    idx               = idx + 1;
                end
            end
        end
    end

endmodule

// File: rtl/opc_slot_alloc.sv
module opc_slot_alloc
    import opc_slot_pkg::*;
#(
    parameter logic SUB_CORE = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic [WARP_W-1:0]                 in_warp,
    input  logic [SCHED_W-1:0]                in_sched,
    input  logic                              in_has_sets,
    input  logic [NUM_SRC-1:0]                in_src_vld,
    input  logic [NUM_SRC*REG_W-1:0]          in_src_reg,
    input  logic [NUM_SETS-1:0]               set_vld,
    input  logic [NUM_SETS*WARP_W-1:0]        set_warp,
    input  logic [NUM_SETS-1:0]               set_has_inst,
    input  logic [NUM_SETS*NUM_SRC-1:0]       set_src_vld,
    input  logic [NUM_SETS*NUM_SRC*REG_W-1:0] set_src_reg,
    input  logic                              done_i,
    output logic                              accept_o,
    output logic                              busy_o,
    output logic [WARP_W-1:0]                 own_warp_o,
    output logic                              own_has_sets_o,
    output logic [NSLOT-1:0]                  not_ready_o,
    output logic [NSLOT*REG_W-1:0]            slot_reg_o,
    output logic [NSLOT*WARP_W-1:0]           slot_warp_o,
    output logic [NSLOT*BANK_W-1:0]           slot_bank_o
);

    logic [NUM_SRC-1:0]          prim_keep;
    logic [NUM_SETS*NUM_SRC-1:0] set_keep;
    logic [NUM_SETS-1:0]         set_en;
    slot_t [NSLOT-1:0]           nxt_slots;
    logic [NSLOT-1:0]            nxt_fill;
    slot_t [NSLOT-1:0]           tab_q;
    logic [NSLOT-1:0]            nr_q;
    logic                        busy_q;
    logic [WARP_W-1:0]           warp_q;
    logic                        sets_q;

    opc_src_dedup u_prim_dedup (
        .vld_i  (in_src_vld),
        .regs_i (in_src_reg),
        .keep_o (prim_keep)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        opc_src_dedup u_set_dedup (
            .vld_i  (set_src_vld[s*NUM_SRC +: NUM_SRC]),
            .regs_i (set_src_reg[s*NUM_SRC*REG_W +: NUM_SRC*REG_W]),
            .keep_o (set_keep[s*NUM_SRC +: NUM_SRC])
        );
        assign set_en[s] = in_has_sets && set_vld[s] && set_has_inst[s] &&
                           (set_warp[s*WARP_W +: WARP_W] != in_warp);
    end

    opc_slot_pack #(.SUB_CORE(SUB_CORE)) u_pack (
        .prim_keep_i (prim_keep),
        .prim_regs_i (in_src_reg),
        .prim_warp_i (in_warp),
        .sched_i     (in_sched),
        .set_en_i    (set_en),
        .set_keep_i  (set_keep),
        .set_regs_i  (set_src_reg),
        .set_warps_i (set_warp),
        .slots_o     (nxt_slots),
        .fill_o      (nxt_fill)
    );

    assign accept_o = in_valid && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            tab_q  <= '0;
            nr_q   <= '0;
            warp_q <= '0;
            sets_q <= 1'b0;
        end else if (accept_o) begin
            busy_q <= 1'b1;
            tab_q  <= nxt_slots;
            nr_q   <= nxt_fill;
            warp_q <= in_warp;
            sets_q <= in_has_sets;
        end else if (done_i) begin
            busy_q <= 1'b0;
        end
    end

    assign busy_o         = busy_q;
    assign own_warp_o     = warp_q;
    assign own_has_sets_o = sets_q;
    assign not_ready_o    = nr_q;

    for (genvar i = 0; i < NSLOT; i++) begin : g_out
        assign slot_reg_o [i*REG_W  +: REG_W]  = tab_q[i].rnum;
        assign slot_warp_o[i*WARP_W +: WARP_W] = tab_q[i].warp;
        assign slot_bank_o[i*BANK_W +: BANK_W] = tab_q[i].bank;

        p_empty_clear_r9: assert property (@(posedge clk) disable iff (rst)
            !nr_q[i] |-> (tab_q[i] == '0));
    end

    logic [NUM_SRC-1:0] upper_nr, upper_inc;
    assign upper_nr  = nr_q[NSLOT-1:NUM_SRC];
    assign upper_inc = upper_nr + 1'b1;

    p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> busy_o);

    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !accept_o |=> ($stable(nr_q) && $stable(tab_q)));

    p_primary_invalid_r3: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> ((nr_q[NUM_SRC-1:0] & ~$past(in_src_vld)) == '0));

    p_packed_prefix_r5: assert property (@(posedge clk) disable iff (rst)
        (upper_nr & upper_inc) == '0);

    p_no_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (accept_o && !in_has_sets) |=> (upper_nr == '0));

endmodule

// File: tb/opc_slot_alloc_tb.sv
module opc_slot_alloc_tb_top;

    typedef struct packed {
        logic        has_sets;
        logic [4:0]  warp;
        logic [1:0]  sched;
        logic [3:0]  src_vld;
        logic [31:0] src_reg;
        logic [2:0]  s_vld;
        logic [2:0]  s_has;
        logic [14:0] s_warp;
        logic [11:0] s_src_vld;
        logic [95:0] s_src_reg;
        logic [7:0]  exp_nr;
        logic [63:0] exp_reg;
        logic [39:0] exp_warp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd3, 2'd1, 4'b1111, 32'h40302010, 3'b000, 3'b000, 15'd0, 12'd0, 96'd0,
          8'h0F, 64'h00000000_40302010,
          {5'd0, 5'd0, 5'd0, 5'd0, 5'd3, 5'd3, 5'd3, 5'd3}},
        '{1'b0, 5'd7, 2'd2, 4'b1011, 32'h22551111, 3'b000, 3'b000, 15'd0, 12'd0, 96'd0,
          8'b00001001, {8'h00, 8'h00, 8'h00, 8'h00, 8'h22, 8'h00, 8'h00, 8'h11},
          {5'd0, 5'd0, 5'd0, 5'd0, 5'd7, 5'd0, 5'd0, 5'd7}},
        '{1'b0, 5'd9, 2'd0, 4'b0000, 32'hFFEEDDCC, 3'b000, 3'b000, 15'd0, 12'd0, 96'd0,
          8'h00, 64'd0, 40'd0},
        '{1'b1, 5'd4, 2'd0, 4'b0011, 32'h99990201, 3'b111, 3'b111,
          {5'd12, 5'd10, 5'd4}, {4'b0001, 4'b1101, 4'b1111},
          {32'h00000005, 32'h01057701, 32'hA3A2A1A0},
          8'b01110011, {8'h00, 8'h05, 8'h05, 8'h01, 8'h00, 8'h00, 8'h02, 8'h01},
          {5'd0, 5'd12, 5'd10, 5'd10, 5'd0, 5'd0, 5'd4, 5'd4}},
        '{1'b1, 5'd1, 2'd3, 4'b0001, 32'h00000033, 3'b110, 3'b101,
          {5'd5, 5'd3, 5'd2}, {4'b0010, 4'b1111, 4'b1111},
          {32'h00004400, 32'h23222120, 32'h13121110},
          8'b00010001, {8'h00, 8'h00, 8'h00, 8'h44, 8'h00, 8'h00, 8'h00, 8'h33},
          {5'd0, 5'd0, 5'd0, 5'd5, 5'd0, 5'd0, 5'd0, 5'd1}},
        '{1'b1, 5'd2, 2'd1, 4'b1111, 32'h04030201, 3'b111, 3'b111,
          {5'd8, 5'd7, 5'd6}, {4'b1111, 4'b1111, 4'b0111},
          {32'h33323130, 32'h23222120, 32'h00121110},
          8'hFF, {8'h20, 8'h12, 8'h11, 8'h10, 8'h04, 8'h03, 8'h02, 8'h01},
          {5'd7, 5'd6, 5'd6, 5'd6, 5'd2, 5'd2, 5'd2, 5'd2}},
        '{1'b0, 5'd2, 2'd2, 4'b0001, 32'h00000009, 3'b001, 3'b001,
          {5'd0, 5'd0, 5'd6}, {4'b0000, 4'b0000, 4'b1111},
          {32'h0, 32'h0, 32'h43424140},
          8'h01, {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h09},
          {5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd2}}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R3";
            1: return "R4";
            2: return "R9";
            3: return "R5 R6 R7";
            4: return "R6";
            5: return "R8";
            default: return "R6";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  in_warp = '0;
    logic [1:0]  in_sched = '0;
    logic        in_has_sets = 1'b0;
    logic [3:0]  in_src_vld = '0;
    logic [31:0] in_src_reg = '0;
    logic [2:0]  set_vld = '0;
    logic [14:0] set_warp = '0;
    logic [2:0]  set_has_inst = '0;
    logic [11:0] set_src_vld = '0;
    logic [95:0] set_src_reg = '0;
    logic        done_i = 1'b0;
    logic        accept_o, busy_o, own_has_sets_o;
    logic [4:0]  own_warp_o;
    logic [7:0]  not_ready_o;
    logic [63:0] slot_reg_o;
    logic [39:0] slot_warp_o;
    logic [31:0] slot_bank_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    opc_slot_alloc dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_warp(in_warp),
        .in_sched(in_sched), .in_has_sets(in_has_sets), .in_src_vld(in_src_vld),
        .in_src_reg(in_src_reg), .set_vld(set_vld), .set_warp(set_warp),
        .set_has_inst(set_has_inst), .set_src_vld(set_src_vld),
        .set_src_reg(set_src_reg), .done_i(done_i), .accept_o(accept_o),
        .busy_o(busy_o), .own_warp_o(own_warp_o), .own_has_sets_o(own_has_sets_o),
        .not_ready_o(not_ready_o), .slot_reg_o(slot_reg_o),
        .slot_warp_o(slot_warp_o), .slot_bank_o(slot_bank_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_warp      = v.warp;
        in_sched     = v.sched;
        in_has_sets  = v.has_sets;
        in_src_vld   = v.src_vld;
        in_src_reg   = v.src_reg;
        set_vld      = v.s_vld;
        set_has_inst = v.s_has;
        set_warp     = v.s_warp;
        set_src_vld  = v.s_src_vld;
        set_src_reg  = v.s_src_reg;
    endtask

    // Table contents against one vector; bank from the R10 formula.
    task automatic check_table(input vec_t v, input string tag);
        chk({tag, " not_ready"}, 64'(not_ready_o), 64'(v.exp_nr));
        for (int s = 0; s < 8; s++) begin
            logic [7:0] er;
            logic [4:0] ew;
            logic [3:0] eb;
            er = v.exp_reg[s*8 +: 8];
            ew = v.exp_warp[s*5 +: 5];
            eb = v.exp_nr[s] ? 4'(int'(v.sched) * 4 + ((int'(er) + int'(ew)) % 4)) : 4'd0;
            chk({tag, " slot reg"}, 64'(slot_reg_o[s*8 +: 8]), 64'(er));
            chk("R10 slot warp", 64'(slot_warp_o[s*5 +: 5]), 64'(ew));
            chk("R10 slot bank", 64'(slot_bank_o[s*4 +: 4]), 64'(eb));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset busy", 64'(busy_o), 64'd0);
        chk("R1 reset accept", 64'(accept_o), 64'd0);
        chk("R9 reset not_ready", 64'(not_ready_o), 64'd0);
        chk("R9 reset regs", slot_reg_o, 64'd0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            in_valid = 1'b1;
            #1;
            chk("R1 accept pulse", 64'(accept_o), 64'd1);
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            chk("R1 busy after accept", 64'(busy_o), 64'd1);
            chk("R1 latched warp", 64'(own_warp_o), 64'(VECS[i].warp));
            chk("R1 latched sets flag", 64'(own_has_sets_o), 64'(VECS[i].has_sets));
            check_table(VECS[i], vec_tag(i));
            done_i = 1'b1;
            @(negedge clk);
            done_i = 1'b0;
            #1;
            chk("R2 done clears busy", 64'(busy_o), 64'd0);
        end

        // Directed: refusal while busy, also in the completion cycle.
        @(negedge clk);
        drive(VECS[0]);
        in_valid = 1'b1;
        @(negedge clk);
        drive(VECS[5]);
        #1;
        chk("R2 no accept while busy", 64'(accept_o), 64'd0);
        @(negedge clk);
        #1;
        chk("R2 table held while busy", 64'(not_ready_o), 64'(VECS[0].exp_nr));
        chk("R2 regs held while busy", slot_reg_o, VECS[0].exp_reg);
        done_i = 1'b1;
        #1;
        chk("R2 no accept in done cycle", 64'(accept_o), 64'd0);
        @(negedge clk);
        done_i = 1'b0;
        #1;
        chk("R2 accept once idle", 64'(accept_o), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check_table(VECS[5], "R8");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule